// File: doc/BRIEF.md
# Sequential Non-Restoring Divider (Integer and 16.16 Fixed Point)

This block divides an unsigned 32-bit dividend by an unsigned 32-bit divisor. It has no restoring step. One quotient bit is resolved per clock, and a full division takes 32 clocks. The sign of the running partial remainder decides each step: a negative remainder has the divisor added back, and a non-negative one has it subtracted. No separate restore cycle is needed.

A mode input chooses between two kinds of division, and it is sampled when an operation is accepted:

- **Integer:** the quotient register is loaded with the dividend and the remainder starts at zero.
- **16.16 fixed point:** the dividend is split before the loop. Its upper 16 bits seed the remainder, and its lower 16 bits are placed in the upper half of the quotient register. The loop then effectively divides the dividend scaled by 2^16.

After the last step the quotient is presented on its output. The remainder output keeps the final partial remainder exactly as the loop left it; no correction step is applied. Both values stay put until the next operation is accepted.

Top module: `divNonRestoring`

## Requirements
- R1: In integer mode (`fracMode`=0) with a divisor from 1 to 2^31, `quotient` equals floor(dividend / divisor).
- R2: In fixed-point mode (`fracMode`=1) with a divisor from 1 to 2^31 and (dividend >> 16) < divisor, `quotient` equals floor(dividend * 2^16 / divisor), truncated to 32 bits.
- R3: `fracMode`, `dividend` and `divisor` are sampled only in the cycle a start is accepted; changing them during a run has no effect on that run's result.
- R4: Let rt be the true remainder of the division selected by R1 or R2. If bit 0 of `quotient` is 1, `remainder` equals rt. If that bit is 0, `remainder` equals (rt − divisor) mod 2^32, which is the uncorrected negative partial remainder.
- R5: A start is accepted when `start`=1 and `busy`=0. `busy` is high from the cycle after acceptance for exactly 32 consecutive cycles.
- R6: `done` is high for exactly one cycle. That cycle is the first one in which `busy` is low again, and `quotient` and `remainder` are already final in it.
- R7: A `start` pulse while `busy`=1 is ignored: the run continues with its original operands and its length is unchanged.
- R8: In integer mode, a zero divisor with dividend bit 31 clear gives `quotient` = 0xFFFFFFFF and `remainder` = dividend, with no other indication.
- R9: After reset, `busy`, `done`, `quotient` and `remainder` are all 0.
- R10: `quotient` and `remainder` hold their values from `done` until the next accepted start.
- R11: After every iteration, the newest quotient bit (bit 0) equals the inverse of the new partial remainder's bit 31.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rstN | input | 1 | Asynchronous active-low reset |
| start | input | 1 | Request a division; accepted only while idle |
| dividend | input | 32 | Unsigned dividend |
| divisor | input | 32 | Unsigned divisor |
| fracMode | input | 1 | 1 = 16.16 fixed point, 0 = integer |
| busy | output | 1 | High while iterations are running |
| done | output | 1 | One-cycle pulse when the result is ready |
| quotient | output | 32 | Quotient result |
| remainder | output | 32 | Final uncorrected partial remainder |

## Verification
The hardest situation to reach from the ports is a start pulse that arrives in the middle of a run, carrying operands and a mode that differ from the run in progress. The stimulus raises `start` several cycles into an integer division and at the same moment switches `fracMode` and both operands. It then checks three things: the run still lasts 32 cycles, the result matches the first operands, and the later request was never taken. The negative-remainder case is reached on purpose as well. Operands whose last quotient bit is 0 expose the uncorrected remainder. A zero divisor is applied to show the quotient saturating with no trap.

// File: rtl/divNrPkg.sv
package divNrPkg;
  // Strobes from the sequencer to the datapath
  typedef struct packed {
    logic load;   // capture operands and seed the registers
    logic step;   // perform one non-restoring iteration
  } divStrobes_t;
endpackage

// File: rtl/divNrCtrl.sv
module divNrCtrl
  import divNrPkg::*;
#(
  parameter int WIDTH = 32
) (
  input  logic        clk,
  input  logic        rstN,
  input  logic        start,
  output divStrobes_t strobes,
  output logic        busy,
  output logic        done
);
  localparam int CNT_W = $clog2(WIDTH);

  logic [CNT_W-1:0] iterCnt;
  logic             lastStep;

  assign lastStep      = (iterCnt == CNT_W'(WIDTH - 1));
  assign strobes.load  = start & ~busy;
  assign strobes.step  = busy;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      busy    <= 1'b0;
      done    <= 1'b0;
      iterCnt <= '0;
    end else begin
      done <= 1'b0;
      if (strobes.load) begin
        busy    <= 1'b1;
        iterCnt <= '0;
      end else if (busy) begin
        iterCnt <= iterCnt + 1'b1;
        if (lastStep) begin
          busy <= 1'b0;
          done <= 1'b1;
        end
      end
    end
  end

  // R6: done never lasts two cycles
  assert_done_single_R6: assert property (@(posedge clk) disable iff (!rstN)
    done |=> !done);

  // R6: busy only drops together with the done pulse
  assert_busy_fall_done_R6: assert property (@(posedge clk) disable iff (!rstN)
    $fell(busy) |-> done);

  // R7: a start while running keeps the run going (unless it was the last step)
  assert_start_ignored_R7: assert property (@(posedge clk) disable iff (!rstN)
    (busy && start && !lastStep) |=> busy);

  // Strobes are mutually exclusive
  assert_strobe_excl_R5: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strobes.load, strobes.step}));
endmodule

// File: rtl/divNrDatapath.sv
module divNrDatapath
  import divNrPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int FRAC_BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  divStrobes_t      strobes,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             fracMode,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int INT_BITS = WIDTH - FRAC_BITS;

  logic [WIDTH-1:0] quoReg;
  logic [WIDTH-1:0] remReg;
  logic [WIDTH-1:0] divReg;
  logic [WIDTH-1:0] shiftedRem;
  logic [WIDTH-1:0] nextRem;
  logic             remNeg;

  always_comb begin
    remNeg     = remReg[WIDTH-1];
    shiftedRem = {remReg[WIDTH-2:0], quoReg[WIDTH-1]};
    nextRem    = remNeg ? (shiftedRem + divReg) : (shiftedRem - divReg);
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      quoReg <= '0;
      remReg <= '0;
      divReg <= '0;
    end else if (strobes.load) begin
      divReg <= divisor;
      if (fracMode) begin
        remReg <= dividend >> INT_BITS;
        quoReg <= dividend << FRAC_BITS;
      end else begin
        remReg <= '0;
        quoReg <= dividend;
      end
    end else if (strobes.step) begin
      remReg <= nextRem;
      quoReg <= {quoReg[WIDTH-2:0], ~nextRem[WIDTH-1]};
    end
  end

  assign quotient  = quoReg;
  assign remainder = remReg;

  // R11: each new quotient bit is the inverse of the updated remainder sign
  assert_qbit_sign_R11: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> (quoReg[0] == ~remReg[WIDTH-1]));

  // R3: the captured divisor does not move during a run
  assert_divisor_stable_R3: assert property (@(posedge clk) disable iff (!rstN)
    strobes.step |=> $stable(divReg));

  // R10: results hold while idle and no start is accepted
  assert_hold_idle_R10: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.load && !strobes.step) |=> ($stable(quoReg) && $stable(remReg)));
endmodule

// File: rtl/divNonRestoring.sv
module divNonRestoring
  import divNrPkg::*;
#(
  parameter int WIDTH     = 32,
  parameter int FRAC_BITS = 16
) (
  input  logic             clk,
  input  logic             rstN,
  input  logic             start,
  input  logic [WIDTH-1:0] dividend,
  input  logic [WIDTH-1:0] divisor,
  input  logic             fracMode,
  output logic             busy,
  output logic             done,
  output logic [WIDTH-1:0] quotient,
  output logic [WIDTH-1:0] remainder
);
  localparam int RUN_W = $clog2(WIDTH) + 1;

  divStrobes_t strobes;

  divNrCtrl #(.WIDTH(WIDTH)) uCtrl (
    .clk     (clk),
    .rstN    (rstN),
    .start   (start),
    .strobes (strobes),
    .busy    (busy),
    .done    (done)
  );

  divNrDatapath #(.WIDTH(WIDTH), .FRAC_BITS(FRAC_BITS)) uDp (
    .clk       (clk),
    .rstN      (rstN),
    .strobes   (strobes),
    .dividend  (dividend),
    .divisor   (divisor),
    .fracMode  (fracMode),
    .quotient  (quotient),
    .remainder (remainder)
  );

  // Checker: length of the busy window seen at the ports
  logic [RUN_W-1:0] busyRun;
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)     busyRun <= '0;
    else if (busy) busyRun <= busyRun + 1'b1;
    else           busyRun <= '0;
  end

  // R5: every done is preceded by exactly WIDTH busy cycles
  assert_busy_len_R5: assert property (@(posedge clk) disable iff (!rstN)
    done |-> (busyRun == RUN_W'(WIDTH)));

  // R5: an accepted start raises busy on the next cycle
  assert_start_busy_R5: assert property (@(posedge clk) disable iff (!rstN)
    (start && !busy) |=> busy);
endmodule

// File: tb/tb_divNonRestoring.sv
module tb_divNonRestoring;
  localparam int W = 32;
  localparam int NV = 8;

  logic          clk = 1'b0;
  logic          rstN = 1'b0;
  logic          start = 1'b0;
  logic [W-1:0]  dividend = '0;
  logic [W-1:0]  divisor = '0;
  logic          fracMode = 1'b0;
  logic          busy, done;
  logic [W-1:0]  quotient, remainder;

  int checks = 0;
  int fails = 0;
  int cycles = 0;

  always #2 clk = ~clk;  // 250 MHz

  divNonRestoring dut (
    .clk(clk), .rstN(rstN), .start(start), .dividend(dividend),
    .divisor(divisor), .fracMode(fracMode), .busy(busy), .done(done),
    .quotient(quotient), .remainder(remainder)
  );

  // Vector table: {fracMode, dividend, divisor, expected quotient}
  localparam logic [96:0] VEC [NV] = '{
    {1'b0, 32'd100,         32'd7,          32'd14},
    {1'b0, 32'hFFFFFFFF,    32'd1,          32'hFFFFFFFF},
    {1'b0, 32'd12345678,    32'd1000,       32'd12345},
    {1'b0, 32'd5,           32'd9,          32'd0},
    {1'b0, 32'h80000000,    32'h40000000,   32'd2},
    {1'b1, 32'h00010000,    32'd4,          32'h40000000},
    {1'b1, 32'h00000003,    32'h00000010,   32'h00003000},
    {1'b1, 32'h00050000,    32'h00020000,   32'h00028000}
  };

  task automatic check(input string req, input string what,
                       input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  // Remainder rule of R4, computed from true division
  function automatic logic [W-1:0] expRem(input logic fm, input logic [W-1:0] n,
                                          input logic [W-1:0] d);
    logic [63:0] num, q, r;
    num = fm ? {16'b0, n, 16'b0} : {32'b0, n};
    q = num / {32'b0, d};
    r = num % {32'b0, d};
    return q[0] ? r[W-1:0] : (r[W-1:0] - d);
  endfunction

  // Start a division and count busy cycles until it ends; leaves time at the
  // negedge where done should be high.
  task automatic runDiv(input logic fm, input logic [W-1:0] n,
                        input logic [W-1:0] d, output int busyCnt);
    @(negedge clk);
    start = 1'b1; fracMode = fm; dividend = n; divisor = d;
    @(negedge clk);
    start = 1'b0;
    busyCnt = 0;
    while (busy && busyCnt < 100) begin
      busyCnt++;
      @(negedge clk);
    end
  endtask

  always @(posedge clk) begin
    cycles++;
    if (cycles > 100000) begin
      fails++;
      checks++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
      $finish;
    end
  end

  initial begin
    int bc;
    // R9: reset state
    repeat (3) @(negedge clk);
    check("R9", "busy", {31'b0, busy}, 32'd0);
    check("R9", "done", {31'b0, done}, 32'd0);
    check("R9", "quotient", quotient, 32'd0);
    check("R9", "remainder", remainder, 32'd0);
    rstN = 1'b1;

    // R1 R2 R4 R5 R6: table walk
    for (int i = 0; i < NV; i++) begin
      runDiv(VEC[i][96], VEC[i][95:64], VEC[i][63:32], bc);
      check(VEC[i][96] ? "R2" : "R1", "quotient", quotient, VEC[i][31:0]);
      check("R4", "remainder", remainder,
            expRem(VEC[i][96], VEC[i][95:64], VEC[i][63:32]));
      check("R5", "busy cycles", bc, 32'd32);
      check("R6", "done at end", {31'b0, done}, 32'd1);
      @(negedge clk);
      check("R6", "done one cycle", {31'b0, done}, 32'd0);
    end

    // R10: results hold while idle
    repeat (5) @(negedge clk);
    check("R10", "quotient held", quotient, 32'h00028000);
    check("R10", "remainder held", remainder,
          expRem(1'b1, 32'h00050000, 32'h00020000));

    // R7 R3: start and operand/mode change mid-run are ignored
    @(negedge clk);
    start = 1'b1; fracMode = 1'b0; dividend = 32'd100; divisor = 32'd7;
    @(negedge clk);
    start = 1'b0;
    bc = 0;
    repeat (5) begin bc++; @(negedge clk); end
    start = 1'b1; fracMode = 1'b1; dividend = 32'd9; divisor = 32'd3;
    @(negedge clk);
    bc++;
    start = 1'b0;
    while (busy && bc < 100) begin bc++; @(negedge clk); end
    check("R7", "busy cycles with mid-run start", bc, 32'd32);
    check("R3", "quotient uses first operands", quotient, 32'd14);
    check("R3", "remainder uses first operands", remainder, 32'hFFFFFFFB);
    @(negedge clk);
    check("R7", "no second run", {31'b0, busy}, 32'd0);

    // R8: zero divisor in integer mode
    runDiv(1'b0, 32'h12345678, 32'd0, bc);
    check("R8", "quotient", quotient, 32'hFFFFFFFF);
    check("R8", "remainder", remainder, 32'h12345678);
    check("R8", "done", {31'b0, done}, 32'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule